// File: doc/BRIEF.md
# Key-Protected Clock Source Selector and Divider

This block is the clock control unit of a small microcontroller. It produces three output clocks for the core, for peripherals and for low-rate auxiliary timing. Each output picks one of several oscillator sources and divides it by a power of two from 1 to 32. The block also derives a slow module clock, which is the module oscillator divided by 128. That slow clock is offered only to the auxiliary output. Everything runs on one fast system clock. Every oscillator arrives as a one-cycle tick-enable input, and every output clock leaves as a one-cycle tick enable.

Software sets the block up through a four-word register bus. Writes to the source-select, divider and crystal-enable words are refused until a key has been written to the access word. Any other value written there locks the unit again. A new source or divider does not take effect when it is written. It is adopted when the output next completes a tick, and the divide counter restarts at that point, so no output period is ever cut short or stretched by a mix of settings. A crystal oscillator that is switched off stops producing ticks. If an output is running from that crystal, it takes its pending setting at once, so it cannot stay stuck on a dead source.

Top module: `clkSelDiv`

## Requirements
- R1: After reset the unit is locked. Main and subsystem select code 3 (digitally controlled oscillator) and auxiliary selects code 1 (very-low-power oscillator). All divider codes are 0, both crystal enables are 1, and every tick output is 0. Readback is: word 0 = 0x0000, word 1 = 0x0133, word 2 = 0x0000, word 3 = 0x0003.
- R2: A write to word 0 with 0xA5 in bits [15:8] unlocks the unit, and word 0 then reads 1 in bit 0. A write to word 0 with any other upper byte locks the unit, and word 0 then reads 0.
- R3: While the unit is locked, writes to words 1, 2 and 3 change nothing: the readback stays the same and so do the outputs.
- R4: In word 1, main select sits in [2:0], subsystem in [6:4] and auxiliary in [10:8]. Source codes are: 0 low-frequency crystal, 1 very-low-power oscillator, 2 module oscillator, 3 digitally controlled oscillator, 4 high-frequency crystal, 5 slow module clock. Main and subsystem accept codes 0 to 4, and auxiliary accepts 0, 1 and 5. An unaccepted code leaves that field at its previous value, while the other fields of the same write still update.
- R5: In word 2, the divider codes sit at [2:0] (main), [6:4] (subsystem) and [10:8] (auxiliary). Code n divides by 2^min(n,5). An output ticks for one cycle, in the cycle after every 2^n-th tick of its selected source.
- R6: The slow module clock output pulses for one cycle, in the cycle after every 128th module-oscillator tick.
- R7: In word 3, bit 0 enables the low-frequency crystal and bit 1 enables the high-frequency crystal. While a crystal is disabled its ticks reach no output.
- R8: A written source or divider becomes active only at the edge that produces an output tick of that clock. The divide count restarts from zero at that edge.
- R9: When the active source of an output is a disabled crystal, that output adopts its written source and divider at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register word address |
| busWdata | input | 16 | Register write data |
| busRdata | output | 16 | Register read data for busAddr (combinational) |
| lfxtTick | input | 1 | Low-frequency crystal tick |
| vloTick | input | 1 | Very-low-power oscillator tick |
| modTick | input | 1 | Module oscillator tick |
| dcoTick | input | 1 | Digitally controlled oscillator tick |
| hfxtTick | input | 1 | High-frequency crystal tick |
| mainTick | output | 1 | Main clock tick enable |
| subTick | output | 1 | Subsystem clock tick enable |
| auxTick | output | 1 | Auxiliary clock tick enable |
| slowModTick | output | 1 | Slow module clock tick enable (module oscillator / 128) |

## Verification
A corrupt active selection or divide count inside one channel shows up at the very next tick of the source it should have used. The output then ticks in a cycle where none is due, or stays silent where a tick is due, so a cycle-by-cycle comparison catches it within one output period. A wrong lock bit or a wrongly accepted select code shows up on the bus readback in the cycle after the write. A slow-divider count that is off shows up on the next slow pulse, at most 128 module ticks later. A missed adoption at a tick boundary shows up as a period of the wrong length in the output period that follows.

// File: rtl/clkSelDivPkg.sv
package clkSelDivPkg;
  localparam int SRC_W        = 3;
  localparam int DIVC_W       = 3;
  localparam int NUM_CH       = 3;
  localparam int NUM_SRC      = 6;
  localparam int FIELD_STRIDE = 4;

  localparam int CH_MAIN = 0;
  localparam int CH_SUB  = 1;
  localparam int CH_AUX  = 2;

  localparam int ADDR_ACCESS = 0;
  localparam int ADDR_SEL    = 1;
  localparam int ADDR_DIV    = 2;
  localparam int ADDR_OSC    = 3;

  localparam int OSC_LF_BIT = 0;
  localparam int OSC_HF_BIT = 1;

  typedef enum logic [SRC_W-1:0] {
    SRC_LFXT = 3'd0,
    SRC_VLO  = 3'd1,
    SRC_MODO = 3'd2,
    SRC_DCO  = 3'd3,
    SRC_HFXT = 3'd4,
    SRC_SLOW = 3'd5
  } srcCode_e;

  // Configuration handed from the register side to the clock datapath
  typedef struct packed {
    logic [NUM_CH-1:0][SRC_W-1:0]  sel;
    logic [NUM_CH-1:0][DIVC_W-1:0] div;
    logic                          lfEn;
    logic                          hfEn;
  } cfgBus_t;

  function automatic logic srcLegal(input int ch, input logic [SRC_W-1:0] code);
    if (ch == CH_AUX)
      return (code == SRC_LFXT) || (code == SRC_VLO) || (code == SRC_SLOW);
    return code <= SRC_HFXT;
  endfunction

  function automatic logic [SRC_W-1:0] resetSel(input int ch);
    return (ch == CH_AUX) ? SRC_VLO : SRC_DCO;
  endfunction
endpackage

// File: rtl/clkSelDivCtrl.sv
module clkSelDivCtrl
  import clkSelDivPkg::*;
#(
  parameter int               DATA_W = 16,
  parameter int               ADDR_W = 2,
  parameter int               KEY_W  = 8,
  parameter logic [KEY_W-1:0] KEY    = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output cfgBus_t           cfg,
  output logic              unlocked
);
  localparam int KEY_LSB = DATA_W - KEY_W;

  logic [NUM_CH-1:0][SRC_W-1:0]  selQ;
  logic [NUM_CH-1:0][SRC_W-1:0]  selD;
  logic [NUM_CH-1:0][DIVC_W-1:0] divQ;
  logic                          lfEnQ;
  logic                          hfEnQ;
  logic                          wrAccess, wrSel, wrDiv, wrOsc;

  assign wrAccess = busWe && (busAddr == ADDR_W'(ADDR_ACCESS));
  assign wrSel    = busWe && unlocked && (busAddr == ADDR_W'(ADDR_SEL));
  assign wrDiv    = busWe && unlocked && (busAddr == ADDR_W'(ADDR_DIV));
  assign wrOsc    = busWe && unlocked && (busAddr == ADDR_W'(ADDR_OSC));

  // Per-channel legality filter: refused codes keep the old field
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gSelFilt
    logic [SRC_W-1:0] fieldCode;
    assign fieldCode = busWdata[ch*FIELD_STRIDE +: SRC_W];
    assign selD[ch]  = srcLegal(ch, fieldCode) ? fieldCode : selQ[ch];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      lfEnQ    <= 1'b1;
      hfEnQ    <= 1'b1;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        selQ[ch] <= resetSel(ch);
        divQ[ch] <= '0;
      end
    end else begin
      if (wrAccess) unlocked <= (busWdata[KEY_LSB +: KEY_W] == KEY);
      if (wrSel) selQ <= selD;
      if (wrDiv) begin
        for (int ch = 0; ch < NUM_CH; ch++)
          divQ[ch] <= busWdata[ch*FIELD_STRIDE +: DIVC_W];
      end
      if (wrOsc) begin
        lfEnQ <= busWdata[OSC_LF_BIT];
        hfEnQ <= busWdata[OSC_HF_BIT];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(ADDR_ACCESS): busRdata[0] = unlocked;
      ADDR_W'(ADDR_SEL): begin
        for (int ch = 0; ch < NUM_CH; ch++)
          busRdata[ch*FIELD_STRIDE +: SRC_W] = selQ[ch];
      end
      ADDR_W'(ADDR_DIV): begin
        for (int ch = 0; ch < NUM_CH; ch++)
          busRdata[ch*FIELD_STRIDE +: DIVC_W] = divQ[ch];
      end
      ADDR_W'(ADDR_OSC): begin
        busRdata[OSC_LF_BIT] = lfEnQ;
        busRdata[OSC_HF_BIT] = hfEnQ;
      end
      default: ;
    endcase
  end

  assign cfg.sel  = selQ;
  assign cfg.div  = divQ;
  assign cfg.lfEn = lfEnQ;
  assign cfg.hfEn = hfEnQ;
endmodule

// File: rtl/clkSelDivChan.sv
module clkSelDivChan
  import clkSelDivPkg::*;
#(
  parameter int               MAX_DIV_LOG = 5,
  parameter logic [SRC_W-1:0] RESET_SEL   = SRC_DCO
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTicks,
  input  logic [NUM_SRC-1:0] srcDead,
  input  logic [SRC_W-1:0]   reqSel,
  input  logic [DIVC_W-1:0]  reqDiv,
  output logic               outTick
);
  localparam int CNT_W = (MAX_DIV_LOG < 1) ? 1 : MAX_DIV_LOG;

  logic [SRC_W-1:0]  actSel;
  logic [DIVC_W-1:0] actDiv;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lastCnt;
  logic              selTick, selDead, wrap, adopt;
  int                divLog;

  always_comb begin
    divLog  = (int'(actDiv) > MAX_DIV_LOG) ? MAX_DIV_LOG : int'(actDiv);
    lastCnt = CNT_W'((1 << divLog) - 1);
    selTick = 1'b0;
    selDead = 1'b0;
    if (int'(actSel) < NUM_SRC) begin
      selTick = srcTicks[actSel];
      selDead = srcDead[actSel];
    end
    wrap  = selTick && (cnt == lastCnt);
    adopt = wrap || selDead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel  <= RESET_SEL;
      actDiv  <= '0;
      cnt     <= '0;
      outTick <= 1'b0;
    end else begin
      outTick <= wrap;
      if (adopt) begin
        actSel <= reqSel;
        actDiv <= reqDiv;
        cnt    <= '0;
      end else if (selTick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkSelDivPath.sv
module clkSelDivPath
  import clkSelDivPkg::*;
#(
  parameter int MAX_DIV_LOG  = 5,
  parameter int SLOW_DIV_LOG = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgBus_t           cfg,
  input  logic              lfxtTick,
  input  logic              vloTick,
  input  logic              modTick,
  input  logic              dcoTick,
  input  logic              hfxtTick,
  output logic [NUM_CH-1:0] chTick,
  output logic              slowTick
);
  logic [NUM_SRC-1:0]      srcTicks;
  logic [NUM_SRC-1:0]      srcDead;
  logic [SLOW_DIV_LOG-1:0] slowCnt;

  always_comb begin
    srcTicks           = '0;
    srcTicks[SRC_LFXT] = lfxtTick && cfg.lfEn;
    srcTicks[SRC_VLO]  = vloTick;
    srcTicks[SRC_MODO] = modTick;
    srcTicks[SRC_DCO]  = dcoTick;
    srcTicks[SRC_HFXT] = hfxtTick && cfg.hfEn;
    srcTicks[SRC_SLOW] = slowTick;
    srcDead            = '0;
    srcDead[SRC_LFXT]  = !cfg.lfEn;
    srcDead[SRC_HFXT]  = !cfg.hfEn;
  end

  // Fixed power-of-two prescaler on the module oscillator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowCnt  <= '0;
      slowTick <= 1'b0;
    end else begin
      slowTick <= modTick && (&slowCnt);
      if (modTick) slowCnt <= slowCnt + 1'b1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    localparam logic [SRC_W-1:0] RST_SEL = resetSel(ch);
    clkSelDivChan #(
      .MAX_DIV_LOG(MAX_DIV_LOG),
      .RESET_SEL  (RST_SEL)
    ) uChan (
      .clk     (clk),
      .rstN    (rstN),
      .srcTicks(srcTicks),
      .srcDead (srcDead),
      .reqSel  (cfg.sel[ch]),
      .reqDiv  (cfg.div[ch]),
      .outTick (chTick[ch])
    );
  end
endmodule

// File: rtl/clkSelDiv.sv
module clkSelDiv
  import clkSelDivPkg::*;
#(
  parameter int               DATA_W       = 16,
  parameter int               ADDR_W       = 2,
  parameter int               KEY_W        = 8,
  parameter logic [KEY_W-1:0] KEY          = 8'hA5,
  parameter int               MAX_DIV_LOG  = 5,
  parameter int               SLOW_DIV_LOG = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              lfxtTick,
  input  logic              vloTick,
  input  logic              modTick,
  input  logic              dcoTick,
  input  logic              hfxtTick,
  output logic              mainTick,
  output logic              subTick,
  output logic              auxTick,
  output logic              slowModTick
);
  cfgBus_t           cfgBus;
  logic              unlockedQ;
  logic [NUM_CH-1:0] chTick;

  clkSelDivCtrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY(KEY)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .cfg     (cfgBus),
    .unlocked(unlockedQ)
  );

  clkSelDivPath #(
    .MAX_DIV_LOG(MAX_DIV_LOG), .SLOW_DIV_LOG(SLOW_DIV_LOG)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfgBus),
    .lfxtTick(lfxtTick),
    .vloTick (vloTick),
    .modTick (modTick),
    .dcoTick (dcoTick),
    .hfxtTick(hfxtTick),
    .chTick  (chTick),
    .slowTick(slowModTick)
  );

  assign mainTick = chTick[CH_MAIN];
  assign subTick  = chTick[CH_SUB];
  assign auxTick  = chTick[CH_AUX];
endmodule

// File: rtl/clkSelDivChk.sv
module clkSelDivChk
  import clkSelDivPkg::*;
#(
  parameter int               DATA_W = 16,
  parameter int               ADDR_W = 2,
  parameter int               KEY_W  = 8,
  parameter logic [KEY_W-1:0] KEY    = 8'hA5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              lfxtTick,
  input logic              vloTick,
  input logic              modTick,
  input logic              dcoTick,
  input logic              hfxtTick,
  input logic              mainTick,
  input logic              subTick,
  input logic              auxTick,
  input logic              slowModTick,
  input logic              unlocked,
  input cfgBus_t           cfg
);
  localparam int KEY_LSB = DATA_W - KEY_W;

  logic anySrc;
  assign anySrc = lfxtTick || vloTick || modTick || dcoTick || hfxtTick;

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(ADDR_ACCESS) && busWdata[KEY_LSB +: KEY_W] == KEY) |=> unlocked);

  assert_wrong_key_locks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(ADDR_ACCESS) && busWdata[KEY_LSB +: KEY_W] != KEY) |=> !unlocked);

  assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !unlocked && busAddr != ADDR_W'(ADDR_ACCESS)) |=> $stable(cfg));

  assert_main_sel_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfg.sel[CH_MAIN] <= SRC_HFXT && cfg.sel[CH_SUB] <= SRC_HFXT);

  assert_aux_sel_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfg.sel[CH_AUX] == SRC_LFXT || cfg.sel[CH_AUX] == SRC_VLO || cfg.sel[CH_AUX] == SRC_SLOW);

  assert_tick_has_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mainTick || subTick) |-> $past(anySrc));

  assert_aux_tick_has_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    auxTick |-> $past(lfxtTick || vloTick || slowModTick));

  assert_slow_follows_mod_R6: assert property (@(posedge clk) disable iff (!rstN)
    slowModTick |-> $past(modTick));

  assert_slow_single_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    slowModTick |=> !slowModTick);
endmodule

bind clkSelDiv clkSelDivChk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY(KEY)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busWe      (busWe),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .lfxtTick   (lfxtTick),
  .vloTick    (vloTick),
  .modTick    (modTick),
  .dcoTick    (dcoTick),
  .hfxtTick   (hfxtTick),
  .mainTick   (mainTick),
  .subTick    (subTick),
  .auxTick    (auxTick),
  .slowModTick(slowModTick),
  .unlocked   (unlockedQ),
  .cfg        (cfgBus)
);

// File: tb/clkSelDiv_bench.sv
module clkSelDiv_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        lfxtTick = 1'b0, vloTick = 1'b0, modTick = 1'b0, dcoTick = 1'b0, hfxtTick = 1'b0;
  logic        mainTick, subTick, auxTick, slowModTick;

  always #4 clk = ~clk;

  clkSelDiv u_clkSelDiv (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .lfxtTick(lfxtTick), .vloTick(vloTick), .modTick(modTick),
    .dcoTick(dcoTick), .hfxtTick(hfxtTick), .mainTick(mainTick), .subTick(subTick),
    .auxTick(auxTick), .slowModTick(slowModTick)
  );

  typedef struct {
    logic [3:0] outs;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  int trafCyc = 0;

  // Expected-behaviour state, kept from the requirements
  bit mUnl, mLf, mHf, mSlowOut;
  int mSel[3], mDiv[3], mAct[3], mActD[3], mCnt[3];
  int mSlowCnt;

  task automatic modelReset();
    mUnl = 0; mLf = 1; mHf = 1; mSlowOut = 0; mSlowCnt = 0;
    for (int ch = 0; ch < 3; ch++) begin
      mSel[ch] = (ch == 2) ? 1 : 3;
      mDiv[ch] = 0;
      mAct[ch] = mSel[ch];
      mActD[ch] = 0;
      mCnt[ch] = 0;
    end
  endtask

  task automatic cycle(input bit we, input logic [1:0] addr, input logic [15:0] wdata,
                       input logic [4:0] mask, input bit doRd, input logic [15:0] expRd,
                       input string req);
    expItem_t it;
    bit nOut[3];
    bit nSlow, tck, wrapX;
    bit st[6];
    bit dd[6];
    int lim, code;
    @(negedge clk);
    busWe = we; busAddr = addr; busWdata = wdata;
    {hfxtTick, dcoTick, modTick, vloTick, lfxtTick} = mask;
    st[0] = mask[0] && mLf; st[1] = mask[1]; st[2] = mask[2];
    st[3] = mask[3]; st[4] = mask[4] && mHf; st[5] = mSlowOut;
    for (int s = 0; s < 6; s++) dd[s] = 0;
    dd[0] = !mLf; dd[4] = !mHf;
    for (int ch = 0; ch < 3; ch++) begin
      lim = 1 << ((mActD[ch] > 5) ? 5 : mActD[ch]);
      tck = st[mAct[ch]];
      wrapX = tck && (mCnt[ch] == lim - 1);
      nOut[ch] = wrapX;
      if (wrapX || dd[mAct[ch]]) begin
        mAct[ch] = mSel[ch]; mActD[ch] = mDiv[ch]; mCnt[ch] = 0;
      end else if (tck) mCnt[ch]++;
    end
    nSlow = mask[2] && (mSlowCnt == 127);
    if (mask[2]) mSlowCnt = (mSlowCnt + 1) % 128;
    mSlowOut = nSlow;
    if (we) begin
      case (addr)
        2'd0: mUnl = (wdata[15:8] == 8'hA5);
        2'd1: if (mUnl) for (int ch = 0; ch < 3; ch++) begin
          code = int'(wdata[ch*4 +: 3]);
          if ((ch == 2) ? (code == 0 || code == 1 || code == 5) : (code <= 4)) mSel[ch] = code;
        end
        2'd2: if (mUnl) for (int ch = 0; ch < 3; ch++) mDiv[ch] = int'(wdata[ch*4 +: 3]);
        default: if (mUnl) begin mLf = wdata[0]; mHf = wdata[1]; end
      endcase
    end
    it.outs = {nOut[0], nOut[1], nOut[2], nSlow};
    it.req = req;
    expQ.push_back(it);
    if (doRd) begin
      #1;
      compared++;
      if (busRdata !== expRd) begin
        mismatched++;
        $display("FAIL %s: read word %0d got 0x%h expected 0x%h", req, addr, busRdata, expRd);
      end
    end
  endtask

  task automatic writeReg(input logic [1:0] addr, input logic [15:0] data, input string req);
    cycle(1'b1, addr, data, 5'b0, 1'b0, 16'h0, req);
  endtask

  task automatic readChk(input logic [1:0] addr, input logic [15:0] expv, input string req);
    cycle(1'b0, addr, 16'h0, 5'b0, 1'b1, expv, req);
  endtask

  task automatic traffic(input int n, input string req);
    logic [4:0] m;
    for (int i = 0; i < n; i++) begin
      m[0] = (trafCyc % 3) == 0;
      m[1] = (trafCyc % 5) == 0;
      m[2] = 1'b1;
      m[3] = (trafCyc % 2) == 0;
      m[4] = (trafCyc % 4) == 0;
      trafCyc++;
      cycle(1'b0, 2'd0, 16'h0, m, 1'b0, 16'h0, req);
    end
  endtask

  // Monitor: compares each cycle's outputs against the queued expectation
  initial begin
    expItem_t got;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        got = expQ.pop_front();
        compared++;
        if ({mainTick, subTick, auxTick, slowModTick} !== got.outs) begin
          mismatched++;
          $display("FAIL %s: ticks main/sub/aux/slow got %b expected %b", got.req,
                   {mainTick, subTick, auxTick, slowModTick}, got.outs);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    readChk(2'd0, 16'h0000, "R1");
    readChk(2'd1, 16'h0133, "R1");
    readChk(2'd2, 16'h0000, "R1");
    readChk(2'd3, 16'h0003, "R1");
    repeat (4) cycle(1'b0, 2'd0, 16'h0, 5'b0, 1'b0, 16'h0, "R1");
    // R5: default divide by one from the default sources
    traffic(20, "R5");
    // R3: locked writes refused
    writeReg(2'd1, 16'h0000, "R3");
    writeReg(2'd3, 16'h0000, "R3");
    writeReg(2'd2, 16'h0555, "R3");
    readChk(2'd1, 16'h0133, "R3");
    readChk(2'd3, 16'h0003, "R3");
    readChk(2'd2, 16'h0000, "R3");
    traffic(10, "R3");
    // R2: key handling
    writeReg(2'd0, 16'hA500, "R2");
    readChk(2'd0, 16'h0001, "R2");
    writeReg(2'd0, 16'h1200, "R2");
    readChk(2'd0, 16'h0000, "R2");
    writeReg(2'd0, 16'hA5FF, "R2");
    readChk(2'd0, 16'h0001, "R2");
    // R4: legality filter per field
    writeReg(2'd1, 16'h0247, "R4");
    readChk(2'd1, 16'h0143, "R4");
    writeReg(2'd1, 16'h0520, "R4");
    readChk(2'd1, 16'h0520, "R4");
    // R5: dividers, including code 6 treated as 32
    writeReg(2'd2, 16'h0062, "R5");
    readChk(2'd2, 16'h0062, "R5");
    traffic(300, "R5");
    // R6: auxiliary on the slow module clock
    traffic(300, "R6");
    // R7: crystals off
    writeReg(2'd3, 16'h0000, "R7");
    readChk(2'd3, 16'h0000, "R7");
    traffic(60, "R7");
    // R9: switch main onto a disabled crystal and aux to lf crystal
    writeReg(2'd1, 16'h0034, "R9");
    traffic(40, "R9");
    writeReg(2'd3, 16'h0003, "R7");
    traffic(80, "R7");
    // R8: mid-count divider change taken at the tick boundary
    traffic(5, "R8");
    writeReg(2'd2, 16'h0070, "R8");
    traffic(60, "R8");
    writeReg(2'd1, 16'h0102, "R8");
    writeReg(2'd2, 16'h0713, "R8");
    traffic(200, "R8");
    repeat (3) @(posedge clk);
    #2;
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R5: %0d expected cycles left unchecked, expected 0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule